// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches recent logical-to-physical page translations for one access stream. Each translation keeps its permission and attribute bits. A lookup presents a logical address, a privilege level and a read/write flag. One cycle later the block reports one of three results: a valid translation with its physical address, cacheability code and two user attribute bits; a protection fault; or a miss. A miss also raises a request to an external table walker and carries the address that missed. The walker's answer is loaded through a fill port. A separate instruction-side and data-side cache are two instances of the same module.

Storage is 16 sets of 4 ways. A configuration input picks 4 KB or 8 KB pages. The page size sets how many low address bits pass through untranslated and which bits select the set. Within each set, replacement follows a round-robin pointer. A flush input invalidates every entry in a single cycle.

Top module: `atc_xlate_cache`

## Requirements
- R1: After reset every registered output is zero, and every lookup misses until an entry has been filled.
- R2: With `pg8k`=0 the offset is vaddr[11:0], the set is vaddr[15:12] and the tag is vaddr[31:16]. A translated address is {ppn[19:0], vaddr[11:0]}.
- R3: With `pg8k`=1 the offset is vaddr[12:0], the set is vaddr[16:13] and the tag is vaddr[31:17]. A translated address is {ppn[19:1], vaddr[12:0]}.
- R4: Results appear on the outputs in the cycle after `lk_valid`. With no lookup in the previous cycle, `rsp_valid`, `rsp_hit`, `rsp_fault` and `walk_req` are 0.
- R5: On a miss `walk_req` is 1, `walk_vaddr` equals the looked-up address, and `rsp_hit` and `rsp_fault` are 0. On a hit or a fault `walk_req` is 0.
- R6: A write that hits an entry with write-protect set gives `rsp_fault`=1 and `rsp_hit`=0. A read of the same entry is a valid translation.
- R7: A user-mode access (`lk_super`=0) that hits a supervisor-only entry gives `rsp_fault`=1 and `rsp_hit`=0. A supervisor access to that entry is allowed.
- R8: On a valid translation, `rsp_cache` and `rsp_uattr` carry the entry's 2-bit cacheability code and 2-bit user attributes. On a miss or a fault, `rsp_paddr`, `rsp_cache` and `rsp_uattr` are zero.
- R9: A fill writes the way that its set's round-robin pointer selects, then advances that pointer from 3 back to 0. A fifth fill to a set evicts the first.
- R10: `flush` invalidates all entries in one cycle. A fill in the same cycle as a flush is discarded.
- R11: A lookup in the same cycle as a fill sees the contents from before the fill. The new entry hits from the next cycle on.
- R12: All four ways of a set can hold distinct pages at once. Sets are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg8k | input | 1 | Page size: 0 = 4 KB, 1 = 8 KB |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Logical address to translate |
| lk_super | input | 1 | 1 = supervisor access, 0 = user access |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| fill_valid | input | 1 | Load a new entry |
| fill_vaddr | input | 32 | Logical address of the page being loaded |
| fill_ppn | input | 20 | Physical page number (4 KB units) |
| fill_wp | input | 1 | Write-protect bit |
| fill_so | input | 1 | Supervisor-only bit |
| fill_cache | input | 2 | Cacheability code |
| fill_uattr | input | 2 | User attribute bits |
| rsp_valid | output | 1 | A lookup result is present |
| rsp_hit | output | 1 | Valid translation |
| rsp_fault | output | 1 | Hit with a protection violation |
| rsp_paddr | output | 32 | Physical address (zero unless valid) |
| rsp_cache | output | 2 | Cacheability code of the hit entry |
| rsp_uattr | output | 2 | User attributes of the hit entry |
| walk_req | output | 1 | Miss: a table walk is needed |
| walk_vaddr | output | 32 | Address that missed |

## Verification
The checks assume that the walker fills a page only when that page is not already cached, so no set ever holds two matching entries. They also assume that `pg8k` changes only together with a flush, so entries are never read under a page size different from the one they were stored with. The stimulus follows both rules. Every fill in it targets a page that has just missed or has never been loaded. The page size changes only after a flush, and only while no lookup or fill is active.

// File: rtl/atc_pkg.sv
package atc_pkg;
    localparam int VA_W   = 32;
    localparam int PG_SH  = 12;
    localparam int PPN_W  = 20;
    localparam int PA_W   = PPN_W + PG_SH;
    localparam int IDX_W  = 4;
    localparam int SETS   = 1 << IDX_W;
    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = VA_W - PG_SH - IDX_W;
    localparam int CM_W   = 2;
    localparam int UA_W   = 2;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic              wp;
        logic              so;
        logic [CM_W-1:0]   cm;
        logic [UA_W-1:0]   ua;
    } atc_ent_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [VA_W-1:0] va, input logic pg8k);
        logic [VA_W-1:0] s;
        s = va >> (PG_SH + int'(pg8k));
        return s[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [VA_W-1:0] va, input logic pg8k);
        logic [VA_W-1:0] s;
        s = va >> (PG_SH + IDX_W + int'(pg8k));
        return s[TAG_W-1:0];
    endfunction

    function automatic logic [PA_W-1:0] pa_of(input logic [PPN_W-1:0] ppn,
                                              input logic [VA_W-1:0] va, input logic pg8k);
        logic [PA_W-1:0] msk;
        msk = '1;
        msk = msk >> (PA_W - PG_SH - int'(pg8k));
        return ({ppn, {PG_SH{1'b0}}} & ~msk) | (PA_W'(va) & msk);
    endfunction
endpackage

// File: rtl/atc_tag_match.sv
module atc_tag_match
    import atc_pkg::*;
#(
    parameter int N_WAY = WAYS,
    localparam int NW_W = $clog2(N_WAY)
) (
    input  atc_ent_t          set_ents [N_WAY],
    input  logic [TAG_W-1:0]  tag,
    output logic              hit,
    output atc_ent_t          hit_ent
);
    logic [N_WAY-1:0] way_eq;

    for (genvar w = 0; w < N_WAY; w++) begin : g_cmp
        assign way_eq[w] = set_ents[w].vld && (set_ents[w].tag == tag);
    end

    always_comb begin
        hit     = |way_eq;
        hit_ent = '0;
        for (int w = N_WAY - 1; w >= 0; w--) begin
            if (way_eq[w]) hit_ent = set_ents[w];
        end
    end
endmodule

// File: rtl/atc_victim_ptr.sv
module atc_victim_ptr #(
    parameter int N_SET = 16,
    parameter int N_WAY = 4,
    localparam int SI_W = $clog2(N_SET),
    localparam int P_W  = $clog2(N_WAY)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [SI_W-1:0] adv_set,
    output logic [P_W-1:0]  rd_ptr
);
    logic [P_W-1:0] ptr_q [N_SET];

    assign rd_ptr = ptr_q[adv_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_SET; s++) ptr_q[s] <= '0;
        end else if (adv) begin
            ptr_q[adv_set] <= (rd_ptr == P_W'(N_WAY - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        adv |=> (ptr_q[$past(adv_set)] ==
                 (($past(rd_ptr) == P_W'(N_WAY - 1)) ? '0 : $past(rd_ptr) + 1'b1))); // R9
endmodule

// File: rtl/atc_perm_check.sv
module atc_perm_check (
    input  logic hit,
    input  logic wp,
    input  logic so,
    input  logic is_write,
    input  logic is_super,
    output logic fault
);
    always_comb begin
        fault = hit && ((is_write && wp) || (!is_super && so));
    end
endmodule

// File: rtl/atc_xlate_cache.sv
module atc_xlate_cache
    import atc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pg8k,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_super,
    input  logic              lk_write,
    input  logic              fill_valid,
    input  logic [VA_W-1:0]   fill_vaddr,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_wp,
    input  logic              fill_so,
    input  logic [CM_W-1:0]   fill_cache,
    input  logic [UA_W-1:0]   fill_uattr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [CM_W-1:0]   rsp_cache,
    output logic [UA_W-1:0]   rsp_uattr,
    output logic              walk_req,
    output logic [VA_W-1:0]   walk_vaddr
);
    atc_ent_t         mem [SETS][WAYS];
    atc_ent_t         sel_set [WAYS];
    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic [WAY_W-1:0] vic_way;
    logic             hit, fault, fill_go;
    atc_ent_t         hit_ent, new_ent;

    assign lk_idx  = idx_of(lk_vaddr, pg8k);
    assign fl_idx  = idx_of(fill_vaddr, pg8k);
    assign fill_go = fill_valid && !flush;

    always_comb begin
        for (int w = 0; w < WAYS; w++) sel_set[w] = mem[lk_idx][w];
        new_ent.vld = 1'b1;
        new_ent.tag = tag_of(fill_vaddr, pg8k);
        new_ent.ppn = fill_ppn;
        new_ent.wp  = fill_wp;
        new_ent.so  = fill_so;
        new_ent.cm  = fill_cache;
        new_ent.ua  = fill_uattr;
    end

    atc_tag_match #(.N_WAY(WAYS)) u_match (
        .set_ents (sel_set),
        .tag      (tag_of(lk_vaddr, pg8k)),
        .hit      (hit),
        .hit_ent  (hit_ent)
    );

    atc_perm_check u_perm (
        .hit      (hit),
        .wp       (hit_ent.wp),
        .so       (hit_ent.so),
        .is_write (lk_write),
        .is_super (lk_super),
        .fault    (fault)
    );

    atc_victim_ptr #(.N_SET(SETS), .N_WAY(WAYS)) u_vic (
        .clk     (clk),
        .rst     (rst),
        .adv     (fill_go),
        .adv_set (fl_idx),
        .rd_ptr  (vic_way)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) mem[s][w].vld <= 1'b0;
        end else if (fill_go) begin
            mem[fl_idx][vic_way] <= new_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_cache  <= '0;
            rsp_uattr  <= '0;
            walk_req   <= 1'b0;
            walk_vaddr <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && hit && !fault;
            rsp_fault  <= lk_valid && fault;
            rsp_paddr  <= (lk_valid && hit && !fault) ? pa_of(hit_ent.ppn, lk_vaddr, pg8k) : '0;
            rsp_cache  <= (lk_valid && hit && !fault) ? hit_ent.cm : '0;
            rsp_uattr  <= (lk_valid && hit && !fault) ? hit_ent.ua : '0;
            walk_req   <= lk_valid && !hit;
            walk_vaddr <= (lk_valid && !hit) ? lk_vaddr : '0;
        end
    end

    AST_WP_FAULT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && hit && lk_write && hit_ent.wp) |=> (rsp_fault && !rsp_hit)); // R6
    AST_SO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && hit && !lk_super && hit_ent.so) |=> (rsp_fault && !rsp_hit)); // R7
    AST_MISS_WALKS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (walk_req != (rsp_hit || rsp_fault))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_fault && !walk_req)); // R4
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && lk_valid) |=> walk_req); // R10
    AST_NO_ATTR_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_paddr == '0 && rsp_cache == '0 && rsp_uattr == '0)); // R8
endmodule

// File: tb/atc_xlate_cache_tb.sv
module atc_xlate_cache_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pg8k = 1'b0, flush = 1'b0;
    logic        lk_valid = 1'b0, lk_super = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_valid = 1'b0, fill_wp = 1'b0, fill_so = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic [19:0] fill_ppn = '0;
    logic [1:0]  fill_cache = '0, fill_uattr = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, walk_req;
    logic [31:0] rsp_paddr, walk_vaddr;
    logic [1:0]  rsp_cache, rsp_uattr;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    atc_xlate_cache u_dut (
        .clk(clk), .rst(rst), .pg8k(pg8k), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_super(lk_super), .lk_write(lk_write),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_ppn(fill_ppn),
        .fill_wp(fill_wp), .fill_so(fill_so), .fill_cache(fill_cache), .fill_uattr(fill_uattr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_cache(rsp_cache), .rsp_uattr(rsp_uattr),
        .walk_req(walk_req), .walk_vaddr(walk_vaddr)
    );

    typedef struct packed {
        logic        fill;
        logic [31:0] va;
        logic        sup;
        logic        wr;
        logic [19:0] ppn;
        logic        wp;
        logic        so;
        logic [1:0]  cm;
        logic [1:0]  ua;
        logic        e_hit;
        logic        e_flt;
        logic [31:0] e_pa;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h0000_1000, 1'b0, 1'b0, 20'h12345, 1'b0, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'hABCD_5000, 1'b0, 1'b0, 20'h00ABC, 1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h0001_5000, 1'b0, 1'b0, 20'h55555, 1'b0, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0000_1234, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 32'h1234_5234},
        '{1'b0, 32'h0000_1FFF, 1'b0, 1'b1, 20'h0, 1'b0, 1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 32'h1234_5FFF},
        '{1'b0, 32'hABCD_5678, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 2'd1, 2'd2, 1'b1, 1'b0, 32'h00AB_C678},
        '{1'b0, 32'hABCD_5678, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0},
        '{1'b0, 32'h0001_5004, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0},
        '{1'b0, 32'h0001_5004, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0, 2'd3, 2'd3, 1'b1, 1'b0, 32'h5555_5004},
        '{1'b0, 32'h0001_6004, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0010_1000, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0002_5000, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] va, input logic [19:0] ppn, input logic wp,
                        input logic so, input logic [1:0] cm, input logic [1:0] ua);
        @(negedge clk);
        fill_valid = 1'b1; fill_vaddr = va; fill_ppn = ppn;
        fill_wp = wp; fill_so = so; fill_cache = cm; fill_uattr = ua;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Drive a lookup at a falling edge, sample the registered result one cycle later.
    task automatic look(input string req, input logic [31:0] va, input logic sup, input logic wr,
                        input logic e_hit, input logic e_flt, input logic [31:0] e_pa,
                        input logic [1:0] e_cm, input logic [1:0] e_ua);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_super = sup; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " valid"}, {31'b0, rsp_valid}, 32'd1);
        chk({req, " hit"}, {31'b0, rsp_hit}, {31'b0, e_hit});
        chk({req, " fault"}, {31'b0, rsp_fault}, {31'b0, e_flt});
        chk({req, " paddr"}, rsp_paddr, e_pa);
        chk({req, " cache/uattr"}, {28'b0, rsp_cache, rsp_uattr}, {28'b0, e_cm, e_ua});
        chk({req, " walk"}, {31'b0, walk_req}, {31'b0, !(e_hit || e_flt)});
        chk({req, " walk_vaddr"}, walk_vaddr, (e_hit || e_flt) ? 32'h0 : va);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 reset outputs", {rsp_valid, rsp_hit, rsp_fault, walk_req, rsp_paddr[27:0]}, 32'h0);
        chk("R1 reset walk_vaddr", walk_vaddr, 32'h0);
        look("R1 empty miss", 32'h0000_1234, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);

        // Vector table: R2 R5 R6 R7 R8 in 4 KB mode
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].fill)
                fill(VEC[i].va, VEC[i].ppn, VEC[i].wp, VEC[i].so, VEC[i].cm, VEC[i].ua);
            else
                look($sformatf("R2/R5/R6/R7/R8 vec%0d", i), VEC[i].va, VEC[i].sup, VEC[i].wr,
                     VEC[i].e_hit, VEC[i].e_flt, VEC[i].e_pa, VEC[i].cm, VEC[i].ua);
        end

        // R4: idle cycle after a lookup
        @(negedge clk);
        chk("R4 idle", {28'b0, rsp_valid, rsp_hit, rsp_fault, walk_req}, 32'h0);

        // R11: lookup during the fill cycle sees old contents
        @(negedge clk);
        fill_valid = 1'b1; fill_vaddr = 32'h0000_7000; fill_ppn = 20'hCAFE0;
        fill_wp = 1'b0; fill_so = 1'b0; fill_cache = 2'd1; fill_uattr = 2'd0;
        lk_valid = 1'b1; lk_vaddr = 32'h0000_7010; lk_super = 1'b0; lk_write = 1'b0;
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        chk("R11 same-cycle miss", {31'b0, walk_req}, 32'd1);
        look("R11 next-cycle hit", 32'h0000_7010, 1'b0, 1'b0, 1'b1, 1'b0, 32'hCAFE_0010, 2'd1, 2'd0);

        // R12 and R9: four pages in set 3, then a fifth evicts the first
        for (int t = 1; t <= 4; t++)
            fill((32'(t) << 16) | 32'h3000, 20'(32'h100 + t), 1'b0, 1'b0, 2'd0, 2'(t));
        for (int t = 1; t <= 4; t++)
            look("R12 four ways", (32'(t) << 16) | 32'h3abc, 1'b1, 1'b0, 1'b1, 1'b0,
                 ((32'h100 + 32'(t)) << 12) | 32'habc, 2'd0, 2'(t));
        fill(32'h0005_3000, 20'h00105, 1'b0, 1'b0, 2'd2, 2'd1);
        look("R9 first evicted", 32'h0001_3000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);
        look("R9 second kept", 32'h0002_3000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0010_2000, 2'd0, 2'd2);
        look("R9 fifth present", 32'h0005_3000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0010_5000, 2'd2, 2'd1);
        look("R12 other set intact", 32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1234_5000, 2'd2, 2'd1);

        // R10: flush clears everything; fill alongside a flush is dropped
        do_flush();
        look("R10 flushed 4K", 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);
        look("R10 flushed set3", 32'h0005_3000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vaddr = 32'h0000_9000; fill_ppn = 20'h11111;
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        look("R10 fill during flush", 32'h0000_9000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);

        // R3: 8 KB pages
        do_flush();
        pg8k = 1'b1;
        fill(32'h0002_A000, 20'h13579, 1'b0, 1'b0, 2'd3, 2'd2);
        look("R3 8K hit", 32'h0002_BFFF, 1'b0, 1'b1, 1'b1, 1'b0, 32'h1357_9FFF, 2'd3, 2'd2);
        look("R3 8K next set miss", 32'h0002_C000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);
        fill(32'h0004_0000, 20'h2468A, 1'b1, 1'b1, 2'd0, 2'd0);
        look("R7 8K user on super page", 32'h0004_0010, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 2'd0, 2'd0);
        look("R6 8K write protected", 32'h0004_0010, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0, 2'd0, 2'd0);
        look("R3 8K super read", 32'h0004_1010, 1'b1, 1'b0, 1'b1, 1'b0, 32'h2468_B010, 2'd0, 2'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule